// File: doc/BRIEF.md
# Tagged Storage Word with Error Correction and Big-Endian Lane Access

This block models one protected storage word: a 64-bit data value beside a 4-bit tag. Each field has its own single-error-correcting, double-error-detecting code. The data value uses 8 check bits, so its codeword is 72 bits. The tag uses 4 check bits, so its codeword is 8 bits. A request may read or write the whole word, or read or write one aligned lane of 32, 16 or 8 bits inside it. Lanes are counted big-endian: byte offset 0 is the most significant byte of the data value.

A read returns the corrected lane, zero-extended or, on request, sign-extended, together with the corrected tag. It reports correction and uncorrectable-error status separately for each field. A sub-word write is a read-modify-write done in the same cycle: the block corrects the stored word, puts the new lane in place, re-encodes both fields and stores them. If either field holds an uncorrectable error, the sub-word write is abandoned and the stored word is not changed. A fault port lets the storage model flip chosen codeword bits, so that the correction paths can be exercised.

Top module: `tagWordStore`

## Requirements
- R1: After reset the word holds data 0 and tag 0. A full read returns both as zero, with every status flag clear.
- R2: The response (`rspValid` and every `rsp*` output) is registered and appears exactly one cycle after the cycle in which `reqValid` is high. A full-size write (size code 3, offset 0) stores both `reqWdata` and `reqWtag`, and a following full read returns them with clean flags.
- R3: Size codes are 0 for a byte, 1 for a 16-bit lane, 2 for a 32-bit lane and 3 for the full 64 bits. A lane of n bytes at byte offset a occupies data bits [63-8a : 64-8a-8n]. An unsigned read returns that lane zero-extended in the low bits of `rspData`.
- R4: With `reqSigned` high, a sub-word read sign-extends the lane from its top bit.
- R5: A sub-word write replaces only the addressed lane, taken from the low bits of `reqWdata`. The other data bits and the tag keep their values.
- R6: A request whose offset is not a multiple of its size in bytes returns `rspAlignErr`. It changes no stored state and returns zero data.
- R7: A single flipped bit anywhere in the 72-bit data codeword is corrected on read and raises `rspDataFix` only.
- R8: A single flipped bit anywhere in the 8-bit tag codeword is corrected on read and raises `rspTagFix` only.
- R9: Two flipped bits in the data codeword raise `rspDataBad`. The tag flags are unaffected.
- R10: Two flipped bits in the tag codeword raise `rspTagBad`. The data flags are unaffected.
- R11: A sub-word write to a word that holds single-bit errors stores the corrected and merged word with fresh check bits. A later read reports no errors.
- R12: A sub-word write to a word with an uncorrectable error in either field raises `rspAbort`. The stored word is left unchanged.
- R13: A full-size write always succeeds, even over an uncorrectable word, and clears all error status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSigned | input | 1 | Sign-extend a sub-word read |
| reqSize | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 full |
| reqOffset | input | 3 | Big-endian byte offset of the lane |
| reqWdata | input | 64 | Write value, lane in the low bits |
| reqWtag | input | 4 | Tag for a full write |
| flipEn | input | 1 | Apply fault masks while no request is present |
| flipData | input | 72 | Bit flips for the data codeword |
| flipTag | input | 8 | Bit flips for the tag codeword |
| rspValid | output | 1 | Response present |
| rspData | output | 64 | Corrected, extended read value |
| rspTag | output | 4 | Corrected tag on reads |
| rspDataFix | output | 1 | Single error corrected in data |
| rspDataBad | output | 1 | Uncorrectable error in data |
| rspTagFix | output | 1 | Single error corrected in tag |
| rspTagBad | output | 1 | Uncorrectable error in tag |
| rspAlignErr | output | 1 | Misaligned request |
| rspAbort | output | 1 | Sub-word write abandoned |

## Verification
The bench builds the block with its default widths: 64 data bits and 4 tag bits. These give a 72-bit data codeword with seven position-parity bits, and an 8-bit tag codeword in the small (7,4) arrangement with an overall parity bit. With these values every one of the eight byte offsets can be driven under all four sizes, including the misaligned ones. Faults can be placed in any bit of either codeword, the overall parity bits included, so each single-error position and a spread of double-error pairs come within reach of random injection.

// File: rtl/tagWordPkg.sv
package tagWordPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_QUAD = 2'd2,
    SZ_FULL = 2'd3
  } accSize_t;

  typedef struct packed {
    logic storeEn;
    logic fullWrite;
    logic readOut;
    logic misaligned;
    logic aborted;
  } ctrlStrobe_t;

  // Number of position-parity bits for k data bits.
  function automatic int hamBits(int k);
    for (int r = 1; r < 32; r++) begin
      if ((1 << r) >= k + r + 1) return r;
    end
    return 31;
  endfunction

  // Data bit index held at a non-power-of-two codeword position.
  function automatic int dataIdx(int p);
    return p - $clog2(p + 1) - 1;
  endfunction

endpackage

// File: rtl/secdedEnc.sv
module secdedEnc #(
  parameter int K = 64
) (
  input  logic [K-1:0] din,
  output logic [K+tagWordPkg::hamBits(K):0] cw
);
  localparam int HR = tagWordPkg::hamBits(K);
  localparam int N  = K + HR + 1;

  function automatic logic [N-1:0] coverMask(int i);
    logic [N-1:0] m;
    m = '0;
    for (int p = 1; p < N; p++) begin
      if (((p >> i) & 1) == 1) m[p] = 1'b1;
    end
    return m;
  endfunction

  logic [N-1:0] spread;
  logic [N-1:0] body;

  assign spread[0] = 1'b0;
  assign body[0]   = 1'b0;

  genvar p;
  generate
    for (p = 1; p < N; p++) begin : g_pos
      if ((p & (p - 1)) == 0) begin : g_par
        localparam logic [N-1:0] CM = coverMask($clog2(p));
        assign spread[p] = 1'b0;
        assign body[p]   = ^(spread & CM);
      end else begin : g_dat
        assign spread[p] = din[tagWordPkg::dataIdx(p)];
        assign body[p]   = spread[p];
      end
    end
  endgenerate

  assign cw = {body[N-1:1], ^body[N-1:1]};
endmodule

// File: rtl/secdedDec.sv
module secdedDec #(
  parameter int K = 64
) (
  input  logic [K+tagWordPkg::hamBits(K):0] cw,
  output logic [K-1:0] dout,
  output logic         fix,
  output logic         bad
);
  localparam int HR = tagWordPkg::hamBits(K);
  localparam int N  = K + HR + 1;

  function automatic logic [N-1:0] coverMask(int i);
    logic [N-1:0] m;
    m = '0;
    for (int p = 1; p < N; p++) begin
      if (((p >> i) & 1) == 1) m[p] = 1'b1;
    end
    return m;
  endfunction

  logic [HR-1:0] syn;
  logic          overall;
  logic [N-1:0]  corr;

  genvar i, p;
  generate
    for (i = 0; i < HR; i++) begin : g_syn
      localparam logic [N-1:0] CM = coverMask(i);
      assign syn[i] = ^(cw & CM);
    end
  endgenerate

  assign overall = ^cw;

  always_comb begin
    corr = cw;
    fix  = 1'b0;
    bad  = 1'b0;
    if (overall) begin
      if (int'(syn) < N) begin
        corr[syn] = ~cw[syn];
        fix = 1'b1;
      end else begin
        bad = 1'b1;
      end
    end else if (syn != '0) begin
      bad = 1'b1;
    end
  end

  generate
    for (p = 1; p < N; p++) begin : g_out
      if ((p & (p - 1)) != 0) begin : g_dat
        assign dout[tagWordPkg::dataIdx(p)] = corr[p];
      end
    end
  endgenerate
endmodule

// File: rtl/tagWordCtrl.sv
module tagWordCtrl
  import tagWordPkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic             dataBad,
  input  logic             tagBad,
  output ctrlStrobe_t      strobe,
  output logic             rspValid,
  output logic             rspAlignErr,
  output logic             rspAbort
);
  logic alignOk;
  logic partWrite;
  logic [OFF_W-1:0] sizeMask;

  always_comb begin
    sizeMask = OFF_W'((1 << reqSize) - 1);
    if (accSize_t'(reqSize) == SZ_FULL) sizeMask = '1;
    alignOk = (reqOffset & sizeMask) == '0;
  end

  assign partWrite = reqValid && reqWrite && alignOk && (accSize_t'(reqSize) != SZ_FULL);

  always_comb begin
    strobe.misaligned = reqValid && !alignOk;
    strobe.fullWrite  = reqValid && reqWrite && alignOk && (accSize_t'(reqSize) == SZ_FULL);
    strobe.aborted    = partWrite && (dataBad || tagBad);
    strobe.storeEn    = strobe.fullWrite || (partWrite && !(dataBad || tagBad));
    strobe.readOut    = reqValid && !reqWrite && alignOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspAlignErr <= 1'b0;
      rspAbort    <= 1'b0;
    end else begin
      rspValid    <= reqValid;
      rspAlignErr <= strobe.misaligned;
      rspAbort    <= strobe.aborted;
    end
  end
endmodule

// File: rtl/tagWordPath.sv
module tagWordPath
  import tagWordPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int OFF_W  = 3,
  parameter int DCW    = 72,
  parameter int TCW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqValid,
  input  logic              reqSigned,
  input  logic [1:0]        reqSize,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [TAG_W-1:0]  reqWtag,
  input  logic              flipEn,
  input  logic [DCW-1:0]    flipData,
  input  logic [TCW-1:0]    flipTag,
  output logic              dataBad,
  output logic              tagBad,
  output logic [DATA_W-1:0] rspData,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspDataFix,
  output logic              rspDataBad,
  output logic              rspTagFix,
  output logic              rspTagBad
);
  localparam int NBYTES = DATA_W / 8;

  logic [DCW-1:0]    dataCw, dataCwNext;
  logic [TCW-1:0]    tagCw, tagCwNext;
  logic [DATA_W-1:0] fixedData, mergedData, laneMask, laneRaw, laneExt;
  logic [TAG_W-1:0]  fixedTag, newTag;
  logic              dataFix, tagFix;
  int                laneBits, shiftBits;

  secdedDec #(.K(DATA_W)) u_decData (.cw(dataCw), .dout(fixedData), .fix(dataFix), .bad(dataBad));
  secdedDec #(.K(TAG_W))  u_decTag  (.cw(tagCw),  .dout(fixedTag),  .fix(tagFix),  .bad(tagBad));

  // Big-endian lane placement: offset 0 sits at the top of the word.
  always_comb begin
    laneBits  = 8 << reqSize;
    shiftBits = (NBYTES - int'(reqOffset)) * 8 - laneBits;
    if (shiftBits < 0) shiftBits = 0;
    laneMask  = {DATA_W{1'b1}} >> (DATA_W - laneBits);
    laneRaw   = (fixedData >> shiftBits) & laneMask;
    laneExt   = laneRaw;
    if (reqSigned && laneRaw[laneBits-1]) laneExt = laneRaw | ~laneMask;
  end

  always_comb begin
    if (strobe.fullWrite) begin
      mergedData = reqWdata;
      newTag     = reqWtag;
    end else begin
      mergedData = (fixedData & ~(laneMask << shiftBits))
                 | ((reqWdata & laneMask) << shiftBits);
      newTag     = fixedTag;
    end
  end

  secdedEnc #(.K(DATA_W)) u_encData (.din(mergedData), .cw(dataCwNext));
  secdedEnc #(.K(TAG_W))  u_encTag  (.din(newTag),     .cw(tagCwNext));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataCw <= '0;
      tagCw  <= '0;
    end else if (strobe.storeEn) begin
      dataCw <= dataCwNext;
      tagCw  <= tagCwNext;
    end else if (flipEn && !reqValid) begin
      dataCw <= dataCw ^ flipData;
      tagCw  <= tagCw ^ flipTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData    <= '0;
      rspTag     <= '0;
      rspDataFix <= 1'b0;
      rspDataBad <= 1'b0;
      rspTagFix  <= 1'b0;
      rspTagBad  <= 1'b0;
    end else begin
      rspData    <= strobe.readOut ? laneExt : '0;
      rspTag     <= strobe.readOut ? fixedTag : '0;
      rspDataFix <= reqValid && dataFix;
      rspDataBad <= reqValid && dataBad;
      rspTagFix  <= reqValid && tagFix;
      rspTagBad  <= reqValid && tagBad;
    end
  end
endmodule

// File: rtl/tagWordStore.sv
module tagWordStore
  import tagWordPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [1:0]        reqSize,
  input  logic [$clog2(DATA_W/8)-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [TAG_W-1:0]  reqWtag,
  input  logic              flipEn,
  input  logic [DATA_W+hamBits(DATA_W):0] flipData,
  input  logic [TAG_W+hamBits(TAG_W):0]   flipTag,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspDataFix,
  output logic              rspDataBad,
  output logic              rspTagFix,
  output logic              rspTagBad,
  output logic              rspAlignErr,
  output logic              rspAbort
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int DCW   = DATA_W + hamBits(DATA_W) + 1;
  localparam int TCW   = TAG_W + hamBits(TAG_W) + 1;

  ctrlStrobe_t strobe;
  logic        dataBad, tagBad;

  tagWordCtrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk, .rstN, .reqValid, .reqWrite, .reqSize, .reqOffset,
    .dataBad, .tagBad, .strobe, .rspValid, .rspAlignErr, .rspAbort
  );

  tagWordPath #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DCW(DCW), .TCW(TCW)
  ) u_path (
    .clk, .rstN, .strobe, .reqValid, .reqSigned, .reqSize, .reqOffset,
    .reqWdata, .reqWtag, .flipEn, .flipData, .flipTag,
    .dataBad, .tagBad, .rspData, .rspTag,
    .rspDataFix, .rspDataBad, .rspTagFix, .rspTagBad
  );
endmodule

// File: rtl/tagWordChk.sv
module tagWordChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        reqSigned,
  input logic [1:0]  reqSize,
  input logic [2:0]  reqOffset,
  input logic        rspValid,
  input logic [63:0] rspData,
  input logic        rspDataFix,
  input logic        rspDataBad,
  input logic        rspTagFix,
  input logic        rspTagBad,
  input logic        rspAlignErr,
  input logic        rspAbort
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_half_misalign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd1 && reqOffset[0]) |=> rspAlignErr);

  assert_byte_zero_ext_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqSigned && reqSize == 2'd0) |=> (rspData[63:8] == 56'd0));

  assert_abort_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> ((rspDataBad || rspTagBad) && !rspAlignErr));

  assert_fix_bad_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspDataFix && rspDataBad));

  assert_tag_fix_bad_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspTagFix && rspTagBad));
endmodule

bind tagWordStore tagWordChk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSigned(reqSigned), .reqSize(reqSize), .reqOffset(reqOffset),
  .rspValid(rspValid), .rspData(rspData), .rspDataFix(rspDataFix),
  .rspDataBad(rspDataBad), .rspTagFix(rspTagFix), .rspTagBad(rspTagBad),
  .rspAlignErr(rspAlignErr), .rspAbort(rspAbort)
);

// File: tb/tagWordStore_tb.sv
`timescale 1ns/1ps
module tagWordStore_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSigned = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [2:0]  reqOffset = '0;
  logic [63:0] reqWdata = '0;
  logic [3:0]  reqWtag = '0;
  logic        flipEn = 1'b0;
  logic [71:0] flipData = '0;
  logic [7:0]  flipTag = '0;
  logic        rspValid;
  logic [63:0] rspData;
  logic [3:0]  rspTag;
  logic        rspDataFix, rspDataBad, rspTagFix, rspTagBad, rspAlignErr, rspAbort;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mData = '0;
  logic [3:0]  mTag = '0;
  int          dErr = 0, tErr = 0;

  always #2.5 clk = ~clk;

  tagWordStore u_dut (
    .clk, .rstN, .reqValid, .reqWrite, .reqSigned, .reqSize, .reqOffset,
    .reqWdata, .reqWtag, .flipEn, .flipData, .flipTag,
    .rspValid, .rspData, .rspTag, .rspDataFix, .rspDataBad,
    .rspTagFix, .rspTagBad, .rspAlignErr, .rspAbort
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] laneMaskOf(int sz);
    return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic int shiftOf(int sz, int off);
    return (8 - off - (1 << sz)) * 8;
  endfunction

  function automatic logic [63:0] expLane(logic [63:0] d, int sz, int off, bit sgn);
    logic [63:0] m = laneMaskOf(sz);
    logic [63:0] r = (d >> shiftOf(sz, off)) & m;
    if (sgn && r[(8 << sz) - 1]) r = r | ~m;
    return r;
  endfunction

  function automatic logic [63:0] expMerge(logic [63:0] d, logic [63:0] w, int sz, int off);
    logic [63:0] m = laneMaskOf(sz);
    int sh = shiftOf(sz, off);
    return (d & ~(m << sh)) | ((w & m) << sh);
  endfunction

  function automatic bit isAligned(int sz, int off);
    return (off % (1 << sz)) == 0;
  endfunction

  // One request; inputs driven at a falling edge, response sampled at the next one.
  task automatic doReq(input string rq, input bit w, input bit sgn, input int sz,
                       input int off, input logic [63:0] wd, input logic [3:0] wt);
    bit al = isAligned(sz, off);
    bit expAbort = 0;
    reqValid = 1; reqWrite = w; reqSigned = sgn; reqSize = 2'(sz);
    reqOffset = 3'(off); reqWdata = wd; reqWtag = wt;
    @(negedge clk);
    reqValid = 0;
    chk(rspValid == 1, rq, "rspValid", 64'(rspValid), 64'd1);
    chk(rspAlignErr == !al, rq, "alignErr", 64'(rspAlignErr), 64'(!al));
    chk(rspDataFix == (dErr == 1), rq, "dataFix", 64'(rspDataFix), 64'(dErr == 1));
    chk(rspDataBad == (dErr == 2), rq, "dataBad", 64'(rspDataBad), 64'(dErr == 2));
    chk(rspTagFix == (tErr == 1), rq, "tagFix", 64'(rspTagFix), 64'(tErr == 1));
    chk(rspTagBad == (tErr == 2), rq, "tagBad", 64'(rspTagBad), 64'(tErr == 2));
    if (!w && al) begin
      if (dErr < 2) chk(rspData == expLane(mData, sz, off, sgn), rq, "rdData",
                        rspData, expLane(mData, sz, off, sgn));
      if (tErr < 2) chk(rspTag == mTag, rq, "rdTag", 64'(rspTag), 64'(mTag));
    end else begin
      chk(rspData == 64'd0, rq, "noData", rspData, 64'd0);
    end
    if (w && al) begin
      if (sz == 3) begin
        mData = wd; mTag = wt; dErr = 0; tErr = 0;
      end else if (dErr == 2 || tErr == 2) begin
        expAbort = 1;
      end else begin
        mData = expMerge(mData, wd, sz, off); dErr = 0; tErr = 0;
      end
    end
    chk(rspAbort == expAbort, rq, "abort", 64'(rspAbort), 64'(expAbort));
  endtask

  // Flip nd data-codeword bits and nt tag-codeword bits (word assumed clean).
  task automatic inject(input int nd, input int nt);
    int a, b;
    flipData = '0; flipTag = '0;
    if (nd > 0) begin
      a = int'($urandom % 72); flipData[a] = 1'b1;
      if (nd > 1) begin b = (a + 1 + int'($urandom % 71)) % 72; flipData[b] = 1'b1; end
    end
    if (nt > 0) begin
      a = int'($urandom % 8); flipTag[a] = 1'b1;
      if (nt > 1) begin b = (a + 1 + int'($urandom % 7)) % 8; flipTag[b] = 1'b1; end
    end
    flipEn = 1;
    @(negedge clk);
    flipEn = 0;
    dErr = nd; tErr = nt;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    chk(rspValid == 0, "R1", "idle rspValid", 64'(rspValid), 64'd0);
    doReq("R1", 0, 0, 3, 0, 0, 0);

    doReq("R2", 1, 0, 3, 0, 64'h0123_4567_89AB_CDEF, 4'hA);
    doReq("R2", 0, 0, 3, 0, 0, 0);
    doReq("R3", 0, 0, 0, 0, 0, 0);
    doReq("R3", 0, 0, 0, 7, 0, 0);
    doReq("R3", 0, 0, 1, 2, 0, 0);
    doReq("R3", 0, 0, 2, 4, 0, 0);
    doReq("R4", 0, 1, 0, 4, 0, 0);
    doReq("R4", 0, 1, 2, 0, 0, 0);
    doReq("R5", 1, 0, 0, 3, 64'hFFFF_FFFF_FFFF_FF5C, 4'h0);
    doReq("R5", 1, 0, 1, 6, 64'h0000_0000_0000_BEEF, 4'h3);
    doReq("R5", 0, 0, 3, 0, 0, 0);
    doReq("R6", 1, 0, 1, 1, 64'hDEAD, 4'h1);
    doReq("R6", 1, 0, 3, 4, 64'hDEAD, 4'h1);
    doReq("R6", 0, 0, 2, 2, 0, 0);
    doReq("R6", 0, 0, 3, 0, 0, 0);
    inject(1, 0); doReq("R7", 0, 0, 3, 0, 0, 0);
    doReq("R7", 1, 0, 3, 0, 64'h5555_AAAA_0F0F_F0F0, 4'h6);
    inject(0, 1); doReq("R8", 0, 0, 3, 0, 0, 0);
    doReq("R8", 1, 0, 3, 0, 64'h1, 4'h9);
    inject(2, 0); doReq("R9", 0, 0, 3, 0, 0, 0);
    doReq("R13", 1, 0, 3, 0, 64'h8000_0000_0000_0001, 4'h5);
    inject(0, 2); doReq("R10", 0, 0, 1, 0, 0, 0);
    doReq("R13", 1, 0, 3, 0, 64'hCAFE_F00D_1234_5678, 4'hC);
    inject(1, 1); doReq("R11", 1, 0, 0, 5, 64'h77, 4'h0);
    doReq("R11", 0, 0, 3, 0, 0, 0);
    inject(2, 0); doReq("R12", 1, 0, 1, 4, 64'h1111, 4'h0);
    doReq("R12", 0, 0, 3, 0, 0, 0);
    doReq("R13", 1, 0, 3, 0, 64'h0F1E_2D3C_4B5A_6978, 4'h7);
    inject(0, 2); doReq("R12", 1, 0, 2, 0, 64'h2222, 4'h0);
    doReq("R12", 0, 0, 3, 0, 0, 0);
    doReq("R13", 1, 0, 3, 0, 64'h0, 4'h0);
    doReq("R13", 0, 0, 3, 0, 0, 0);

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 10);
      int sz = int'($urandom % 4);
      int off = int'($urandom % 8);
      if (($urandom % 4) != 0) off = off & ~((1 << sz) - 1);
      if (op == 0) begin
        if (dErr == 0 && tErr == 0) inject(int'($urandom % 3), int'($urandom % 3));
        else doReq("R13", 1, 0, 3, 0, {$urandom, $urandom}, 4'($urandom));
      end else if (op < 5) begin
        doReq("R3", 0, bit'($urandom % 2), sz, off, 0, 0);
      end else begin
        doReq("R5", 1, 0, sz, off, {$urandom, $urandom}, 4'($urandom));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule